// File: doc/BRIEF.md
# PPS-Disciplined Reference Oscillator Tuner

This block steers a 30.72 MHz reference oscillator towards its nominal frequency, using the one-pulse-per-second output of a satellite timing receiver as the time base. Running in the oscillator's own clock domain, it counts reference cycles between selected pulse edges. It compares each count with the value a perfect oscillator would give and corrects the oscillator's tuning voltage. The correction is made by writing a new code to a serial voltage-control DAC.

Measurements begin with a one-second window. After repeated good results the window is lengthened to ten seconds and then to a hundred seconds, so each step gives a finer count resolution. A large error sends the tuner back to the short window. If the receiver reports no fix, or the pulses stop arriving, the tuner goes idle and holds the last DAC code. The current state is available as a two-bit code, a lock flag and a red/green indicator pair.

Top module: `pps_osc_tuner`

## Requirements
- R1: While `rst` is high and immediately afterwards, `dac_cs_n` is 1, `spi_sclk` and `spi_mosi` are 0, `tune_state` is 0, `locked` is 0, `led_red` is 1 and `led_green` is 0. The DAC code starts at mid-scale (2^(DAC_BITS-1)).
- R2: While `gnss_ok` is low, pulses on `pps_in` start no measurement and cause no DAC write. `tune_state` stays 0 (idle) and the red indicator is solidly on.
- R3: When `gnss_ok` is high in the idle state, the first rising edge of `pps_in` opens a one-second window. `tune_state` becomes 1 and `locked` becomes 1. This edge writes nothing to the DAC.
- R4: A window covers N pulse periods, where N is 1, 10 or 100 for `tune_state` 1, 2 or 3. When it closes, error e = (reference cycles counted) − REF_HZ·N. The new code is old code − GAIN·e, and it is written in exactly one DAC frame. Pulses inside a window do not change the code. The closing edge also opens the next window.
- R5: A computed code below 0 is written as 0. A computed code above 2^DAC_BITS − 1 is written as 2^DAC_BITS − 1.
- R6: A DAC frame has 24 bits, sent MSB first. `dac_cs_n` stays low for the whole frame. `spi_sclk` idles low, and `spi_mosi` is valid on each rising `spi_sclk` edge. The frame's upper 8 bits are 0 and its lower 16 bits hold the code left-aligned, so the frame is {8'h00, code} for a 16-bit DAC and {8'h00, code, 8'h00} for an 8-bit DAC.
- R7: After two consecutive windows with |e| ≤ TOL, the next window is one step longer (1 → 2 → 3 on `tune_state`). In state 3, good windows keep state 3.
- R8: A window with TOL < |e| ≤ DROP leaves `tune_state` unchanged and clears the run of good windows. After it, two further good windows are needed to advance.
- R9: A window with |e| > DROP returns `tune_state` to 1.
- R10: With `gnss_ok` high and no `pps_in` edge for more than 1.5·REF_HZ cycles, the tuner goes idle (`tune_state` 0, `locked` 0). A gap of 1.4·REF_HZ cycles does not do this. The DAC code is held, and the next edge re-arms as in R3.
- R11: Indicators: idle gives red steady on and green off. State 1 gives red blinking and green off. State 2 gives red and green blinking together. State 3 gives green blinking and red off. A blinking colour inverts on every detected pulse edge.
- R12: Dropping `gnss_ok` takes the tuner to idle within a few cycles, and the held DAC code is the base for the first correction after re-arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock, the clock being measured |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous one-pulse-per-second input |
| gnss_ok | input | 1 | Receiver has a valid fix (asynchronous) |
| spi_sclk | output | 1 | Serial clock to the DAC |
| spi_mosi | output | 1 | Serial data to the DAC |
| dac_cs_n | output | 1 | DAC chip select, active low |
| tune_state | output | 2 | 0 idle, 1 one-second, 2 ten-second, 3 hundred-second window |
| locked | output | 1 | Tuner is tracking pulses |
| led_red | output | 1 | Red indicator drive |
| led_green | output | 1 | Green indicator drive |

## Verification
The bench sets REF_HZ to 200, so one "second" lasts 200 clocks. This makes a full hundred-second window cost 20,000 cycles and puts the loss timeout at 300 cycles, so every window length, both sides of the timeout and a drop from the longest window all fit in one run. GAIN is 4, TOL is 1, DROP is 8 and the serial half-period is one clock. Two copies run side by side on the same pulse stream, one with a 16-bit and one with an 8-bit DAC. Errors of ±40 counts drive the narrow copy into both saturation limits while the wide copy stays in range, and the two copies also exercise both frame alignments.

// File: rtl/pps_osc_tuner.sv
module pps_osc_tuner #(
  parameter int unsigned REF_HZ   = 30_720_000,
  parameter int          DAC_BITS = 16,
  parameter int          GAIN     = 2,
  parameter int          TOL      = 1,
  parameter int          DROP     = 64,
  parameter int          SPI_HALF = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pps_in,
  input  logic       gnss_ok,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       dac_cs_n,
  output logic [1:0] tune_state,
  output logic       locked,
  output logic       led_red,
  output logic       led_green
);

  localparam longint EXP1     = longint'(REF_HZ);
  localparam longint EXP10    = longint'(REF_HZ) * 10;
  localparam longint EXP100   = longint'(REF_HZ) * 100;
  localparam int     CNT_W    = $clog2(longint'(REF_HZ) * 150 + 1);
  localparam int     E_W      = CNT_W + 2;
  localparam int     P_W      = E_W + 34;
  localparam int     LOSS     = int'(REF_HZ) + int'(REF_HZ / 2);
  localparam int     SW       = $clog2(LOSS + 1);
  localparam int     CODE_MAX = (1 << DAC_BITS) - 1;
  localparam int     CODE_MID = 1 << (DAC_BITS - 1);
  localparam int     DIV_W    = (SPI_HALF > 1) ? $clog2(SPI_HALF) : 1;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_S1 = 2'd1, ST_S10 = 2'd2, ST_S100 = 2'd3} tst_t;

  logic [2:0]          pps_sy;
  logic [1:0]          ok_sy;
  logic                pps_edge, valid_s;
  tst_t                tst_q;
  logic [CNT_W-1:0]    cnt_q, meas, exp_cnt;
  logic [6:0]          npps_q, npps_last;
  logic [SW-1:0]       since_q;
  logic                good_q, blink_q;
  logic [DAC_BITS-1:0] code_q, nxt_code;
  logic signed [E_W-1:0] err;
  logic [E_W-1:0]      mag;
  logic signed [P_W-1:0] corr, raw;
  logic                gate_close, in_tol, too_far;
  logic [15:0]         code_al;
  logic [23:0]         sh_q;
  logic [4:0]          bits_q;
  logic [DIV_W-1:0]    div_q;
  logic                sclk_q, cs_q;

  assign pps_edge = pps_sy[1] & ~pps_sy[2];
  assign valid_s  = ok_sy[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pps_sy <= '0;
      ok_sy  <= '0;
    end else begin
      pps_sy <= {pps_sy[1:0], pps_in};
      ok_sy  <= {ok_sy[0], gnss_ok};
    end
  end

  always_comb begin
    case (tst_q)
      ST_S10:  begin exp_cnt = CNT_W'(EXP10);  npps_last = 7'd9;  end
      ST_S100: begin exp_cnt = CNT_W'(EXP100); npps_last = 7'd99; end
      default: begin exp_cnt = CNT_W'(EXP1);   npps_last = 7'd0;  end
    endcase
  end

  assign gate_close = pps_edge && valid_s && (tst_q != ST_IDLE) && (npps_q == npps_last);
  assign meas       = cnt_q + CNT_W'(1);
  assign err        = $signed({2'b00, meas}) - $signed({2'b00, exp_cnt});
  assign mag        = err[E_W-1] ? E_W'(-err) : E_W'(err);
  assign in_tol     = mag <= E_W'(TOL);
  assign too_far    = mag > E_W'(DROP);
  assign corr       = P_W'(err) * P_W'(GAIN);
  assign raw        = P_W'(signed'({1'b0, code_q})) - corr;
  assign nxt_code   = (raw < 0) ? '0 :
                      (raw > P_W'(CODE_MAX)) ? DAC_BITS'(CODE_MAX) : raw[DAC_BITS-1:0];
  assign code_al    = 16'(nxt_code) << (16 - DAC_BITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      tst_q   <= ST_IDLE;
      cnt_q   <= '0;
      npps_q  <= '0;
      since_q <= '0;
      good_q  <= 1'b0;
      blink_q <= 1'b0;
      code_q  <= DAC_BITS'(CODE_MID);
    end else begin
      if (pps_edge) blink_q <= ~blink_q;
      if (pps_edge)                  since_q <= '0;
      else if (since_q < SW'(LOSS))  since_q <= since_q + SW'(1);

      if (!valid_s) begin
        tst_q  <= ST_IDLE;
        good_q <= 1'b0;
      end else if (tst_q == ST_IDLE) begin
        if (pps_edge) begin
          tst_q  <= ST_S1;
          cnt_q  <= '0;
          npps_q <= '0;
          good_q <= 1'b0;
        end
      end else if (pps_edge) begin
        if (gate_close) begin
          cnt_q  <= '0;
          npps_q <= '0;
          code_q <= nxt_code;
          if (too_far) begin
            tst_q  <= ST_S1;
            good_q <= 1'b0;
          end else if (in_tol) begin
            if (good_q && tst_q != ST_S100) begin
              tst_q  <= tst_t'(tst_q + 2'd1);
              good_q <= 1'b0;
            end else begin
              good_q <= 1'b1;
            end
          end else begin
            good_q <= 1'b0;
          end
        end else begin
          npps_q <= npps_q + 7'd1;
          cnt_q  <= cnt_q + CNT_W'(1);
        end
      end else if (since_q >= SW'(LOSS)) begin
        tst_q  <= ST_IDLE;
        good_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      bits_q <= '0;
      div_q  <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else if (gate_close) begin
      sh_q   <= {8'h00, code_al};
      bits_q <= '0;
      div_q  <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else if (!cs_q) begin
      if (div_q == DIV_W'(SPI_HALF - 1)) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (bits_q == 5'd23) begin
            cs_q <= 1'b1;
          end else begin
            bits_q <= bits_q + 5'd1;
            sh_q   <= {sh_q[22:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  assign spi_sclk   = sclk_q;
  assign spi_mosi   = ~cs_q & sh_q[23];
  assign dac_cs_n   = cs_q;
  assign tune_state = tst_q;
  assign locked     = (tst_q != ST_IDLE);
  assign led_red    = (tst_q == ST_IDLE) | (((tst_q == ST_S1) | (tst_q == ST_S10)) & blink_q);
  assign led_green  = ((tst_q == ST_S10) | (tst_q == ST_S100)) & blink_q;

  assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (rst)
    cs_q |-> !sclk_q);

  assert_frame_len_R6: assert property (@(posedge clk) disable iff (rst)
    !cs_q |-> (bits_q < 5'd24));

  assert_write_when_free_R4: assert property (@(posedge clk) disable iff (rst)
    gate_close |-> cs_q);

  assert_code_only_at_close_R4: assert property (@(posedge clk) disable iff (rst)
    !gate_close |=> $stable(code_q));

  assert_idle_without_fix_R2: assert property (@(posedge clk) disable iff (rst)
    !valid_s |=> (tst_q == ST_IDLE));

  assert_single_step_R7: assert property (@(posedge clk) disable iff (rst)
    (tst_q == ST_S100 && $past(tst_q) != ST_S100) |-> ($past(tst_q) == ST_S10));

endmodule

// File: tb/test_pps_osc_tuner.sv
module test_pps_osc_tuner;
  localparam int REF = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pps = 1'b0;
  logic ok  = 1'b0;

  logic sclkA, mosiA, csA, lockA, redA, grnA;
  logic sclkB, mosiB, csB, lockB, redB, grnB;
  logic [1:0] stA, stB;

  int checks = 0;
  int failures = 0;
  int elapsed = 0;
  int exp16 = 32768;
  int exp8 = 128;

  always #4 clk = ~clk;

  pps_osc_tuner #(.REF_HZ(REF), .DAC_BITS(16), .GAIN(4), .TOL(1), .DROP(8), .SPI_HALF(1)) i_pps_osc_tuner (
    .clk(clk), .rst(rst), .pps_in(pps), .gnss_ok(ok),
    .spi_sclk(sclkA), .spi_mosi(mosiA), .dac_cs_n(csA),
    .tune_state(stA), .locked(lockA), .led_red(redA), .led_green(grnA));

  pps_osc_tuner #(.REF_HZ(REF), .DAC_BITS(8), .GAIN(4), .TOL(1), .DROP(8), .SPI_HALF(1)) i_pps_osc_tuner_b8 (
    .clk(clk), .rst(rst), .pps_in(pps), .gnss_ok(ok),
    .spi_sclk(sclkB), .spi_mosi(mosiB), .dac_cs_n(csB),
    .tune_state(stB), .locked(lockB), .led_red(redB), .led_green(grnB));

  logic [23:0] shA = '0, lastA = '0, shB = '0, lastB = '0;
  int bitsA = 0, bitsB = 0, nfA = 0, nfB = 0;

  always @(posedge sclkA or posedge csA) begin
    if (csA) begin
      if (bitsA == 24) begin lastA = shA; nfA++; end
      bitsA = 0;
    end else begin
      shA = {shA[22:0], mosiA};
      bitsA++;
    end
  end

  always @(posedge sclkB or posedge csB) begin
    if (csB) begin
      if (bitsB == 24) begin lastB = shB; nfB++; end
      bitsB = 0;
    end else begin
      shB = {shB[22:0], mosiB};
      bitsB++;
    end
  end

  task automatic chk(input bit good, input string tag, input longint act, input longint expv);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    elapsed += n;
  endtask

  task automatic pulse(input int gap);
    if (gap > elapsed) wait_cyc(gap - elapsed);
    pps = 1'b1;
    elapsed = 0;
    wait_cyc(5);
    pps = 1'b0;
  endtask

  task automatic pulses(input int n, input int gap);
    for (int i = 0; i < n; i++) pulse(gap);
  endtask

  function automatic int sat(input int v, input int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  task automatic end_gate(input int e);
    int na, nb;
    na = nfA;
    nb = nfB;
    exp16 = sat(exp16 - 4 * e, 65535);
    exp8  = sat(exp8 - 4 * e, 255);
    wait_cyc(60);
    chk(nfA == na + 1, "R4 one write per window (16-bit)", nfA - na, 1);
    chk(nfB == nb + 1, "R4 one write per window (8-bit)", nfB - nb, 1);
    chk(lastA == {8'h00, 16'(exp16)}, "R6 16-bit frame / R4 code", lastA, {8'h00, 16'(exp16)});
    chk(lastB == {8'h00, 8'(exp8), 8'h00}, "R6 8-bit frame / R5 code", lastB, {8'h00, 8'(exp8), 8'h00});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    chk(csA && csB, "R1 chip select idle", {csA, csB}, 2'b11);
    chk(!sclkA && !mosiA && !sclkB, "R1 serial lines low", {sclkA, mosiA, sclkB}, 0);
    chk(stA == 2'd0 && !lockA, "R1 idle state", {stA, lockA}, 0);
    chk(redA && !grnA, "R1 indicator", {redA, grnA}, 2'b10);
  endtask

  task automatic t_no_fix;
    ok = 1'b0;
    pulses(3, REF);
    wait_cyc(60);
    chk(nfA == 0 && nfB == 0, "R2 no write without fix", nfA + nfB, 0);
    chk(stA == 2'd0 && !lockA, "R2 stays idle", {stA, lockA}, 0);
    chk(redA && !grnA, "R2 red solid", {redA, grnA}, 2'b10);
  endtask

  task automatic t_arm;
    ok = 1'b1;
    pulse(REF);
    wait_cyc(15);
    chk(stA == 2'd1 && lockA, "R3 armed into one-second window", {stA, lockA}, 3'b011);
    chk(nfA == 0, "R3 arming edge writes nothing", nfA, 0);
  endtask

  task automatic t_steer;
    logic r0;
    r0 = redA;
    pulse(REF + 3);
    end_gate(3);
    chk(redA == !r0 && !grnA, "R11 one-second red blink", {redA, grnA}, {!r0, 1'b0});
    chk(stA == 2'd1, "R8 moderate error keeps state", stA, 1);
    pulse(REF - 2);
    end_gate(-2);
    chk(stA == 2'd1, "R8 state after negative error", stA, 1);
  endtask

  task automatic t_saturate;
    pulse(REF + 40);
    end_gate(40);
    chk(stA == 2'd1, "R9 large error in state 1", stA, 1);
    pulse(REF - 40);
    end_gate(-40);
    pulse(REF - 40);
    end_gate(-40);
    chk(lastB[15:8] == 8'hFF, "R5 upper limit reached", lastB[15:8], 8'hFF);
  endtask

  task automatic t_advance;
    pulse(REF);
    end_gate(0);
    chk(stA == 2'd1, "R7 one good window not enough", stA, 1);
    pulse(REF + 1);
    end_gate(1);
    chk(stA == 2'd2, "R7 advance to ten-second window", stA, 2);
    chk(redA == grnA, "R11 ten-second both colours", {redA, grnA}, {grnA, grnA});
  endtask

  task automatic t_ten;
    logic r0, g0;
    r0 = redA;
    g0 = grnA;
    pulse(REF);
    wait_cyc(10);
    chk(redA == !r0 && grnA == !g0, "R11 ten-second blink", {redA, grnA}, {!r0, !g0});
    pulses(9, REF);
    end_gate(0);
    chk(stA == 2'd2, "R7 first ten-second good window", stA, 2);
    pulses(9, REF);
    pulse(REF + 3);
    end_gate(3);
    chk(stA == 2'd2, "R8 run cleared, state held", stA, 2);
    pulses(10, REF);
    end_gate(0);
    chk(stA == 2'd2, "R8 single good window after reset of run", stA, 2);
    pulses(10, REF);
    end_gate(0);
    chk(stA == 2'd3, "R7 advance to hundred-second window", stA, 3);
  endtask

  task automatic t_hundred;
    logic g0;
    g0 = grnA;
    chk(!redA, "R11 red off in hundred-second state", redA, 0);
    pulse(REF);
    wait_cyc(10);
    chk(grnA == !g0 && !redA, "R11 hundred-second green blink", {redA, grnA}, {1'b0, !g0});
    pulses(98, REF);
    pulse(REF + 10);
    end_gate(10);
    chk(stA == 2'd1, "R9 drop back to one-second window", stA, 1);
  endtask

  task automatic t_loss;
    int na;
    pulse(REF);
    end_gate(0);
    na = nfA;
    wait_cyc(280 - elapsed);
    chk(lockA && stA == 2'd1, "R10 still locked at 1.4 s gap", {stA, lockA}, 3'b011);
    wait_cyc(330 - elapsed);
    chk(!lockA && stA == 2'd0, "R10 idle after 1.5 s gap", {stA, lockA}, 0);
    chk(redA && !grnA, "R11 red solid after loss", {redA, grnA}, 2'b10);
    chk(nfA == na, "R10 no write on loss", nfA - na, 0);
    pulse(REF);
    wait_cyc(15);
    chk(stA == 2'd1, "R10 re-armed", stA, 1);
    pulse(REF);
    end_gate(0);
  endtask

  task automatic t_fix_drop;
    int na;
    ok = 1'b0;
    wait_cyc(6);
    chk(stA == 2'd0 && !lockA, "R12 fix drop goes idle", {stA, lockA}, 0);
    na = nfA;
    pulse(REF);
    wait_cyc(60);
    chk(nfA == na && stA == 2'd0, "R12 pulses ignored without fix", nfA - na, 0);
    ok = 1'b1;
    wait_cyc(4);
    pulse(REF);
    wait_cyc(15);
    chk(stA == 2'd1, "R12 re-armed after fix", stA, 1);
    pulse(REF - 3);
    end_gate(-3);
  endtask

  initial begin
    t_reset;
    t_no_fix;
    t_arm;
    t_steer;
    t_saturate;
    t_advance;
    t_ten;
    t_hundred;
    t_loss;
    t_fix_drop;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule